// File: doc/BRIEF.md
# Quarter-Resolution VGA Raster Timing Generator

This block produces the raster timing for a 640x480 monitor mode from a 25 MHz pixel clock, which stands in for the nominal 25.175 MHz. Besides the two active-low sync strobes, it produces coarse framebuffer coordinates. In these coordinates one virtual pixel covers a 4x4 square of monitor pixels. A line is 200 virtual columns wide and a frame is 131 virtual rows tall. Every timing edge is found by an equality match on these coarse counters or on the low bits of a line divider. No fine pixel counter is kept.

The block also has a fine line counter that advances on every monitor line, for a text mode that runs at full vertical resolution. The row counters step early, at the moment a line's visible part ends, and not at the end of the line. This gives downstream fetch logic a full blanking interval with the next row's address already present. The sync timing is measured from the same points, and the end of the vertical sync is taken from the line divider. The display enable is the AND of the horizontal and vertical visible-area flags.

Top module: `vga_timing_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every counter output becomes 0, and `hvis_o`, `vvis_o`, `de_o`, `hsync_n_o` and `vsync_n_o` all become 1.
- R2: `vx_o` advances by one on every fourth rising edge after reset, with the first step on the fourth edge. It wraps from H_TOT-1 (199) to 0.
- R3: `hvis_o` is 0 exactly while `vx_o` is in [H_VIS, H_TOT-1] (160..199), and 1 otherwise.
- R4: `hsync_n_o` is 0 exactly while `vx_o` is in [H_SS, H_SE-1] (164..187), and 1 otherwise.
- R5: A hidden 2-bit line divider steps on the edge where `vx_o` becomes H_VIS. `vy_o` steps on every fourth such event, so a row change is seen only together with `vx_o` = H_VIS.
- R6: `vy_o` wraps from V_TOT-1 (130) to 0. `vvis_o` is 0 exactly while `vy_o` is at least V_VIS (120).
- R7: `vsync_n_o` is 0 exactly while `vy_o` equals V_SS (122) and the line divider is below VS_SUB_END (2). This covers the first two monitor lines of that row, counted from the row's step point.
- R8: `line_o` advances on every line-divider step and returns to 0 when `vy_o` wraps. A frame is therefore 4*V_TOT (524) lines long.
- R9: `de_o` equals `hvis_o` AND `vvis_o` at all times.
- R10: All outputs are registered and change together on the same clock edge. There is no combinational path from `rst` to any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vx_o | output | $clog2(H_TOT) | Virtual column |
| vy_o | output | $clog2(V_TOT) | Virtual row |
| line_o | output | $clog2(4*V_TOT) | Physical monitor line |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| hvis_o | output | 1 | Horizontal visible-area flag |
| vvis_o | output | 1 | Vertical visible-area flag |
| de_o | output | 1 | Display enable |

## Verification
The hardest events to reach are the frame wrap and the full vertical sync window, because they lie more than 400,000 clocks deep at the default geometry. The bench therefore builds the block with a short vertical geometry (9 rows, visible 6, sync row 7) and keeps the horizontal defaults. With that geometry it covers two complete frames and can sweep every clock. Its expected values come from a closed-form count of edges since reset. The line-step count is (edges/4 + 40)/200 in whole numbers, and every other output follows from it.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;
  // Next value of a modulo counter
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
    return (v == lim - 1) ? 0 : v + 1;
  endfunction

  // Half-open membership test [lo, hi)
  function automatic logic in_span(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction
endpackage

// File: rtl/vga_hcount.sv
module vga_hcount #(
  parameter int DIV_W = 2,
  parameter int H_TOT = 200,
  parameter int H_VIS = 160,
  localparam int XW = $clog2(H_TOT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] x_q,
  output logic [XW-1:0] x_d,
  output logic          x_tick,
  output logic          line_step
);
  logic [DIV_W-1:0] div_q;

  assign x_tick    = &div_q;
  assign line_step = x_tick && (x_q == XW'(H_VIS - 1));

  always_comb begin
    x_d = x_q;
    if (x_tick) x_d = XW'(vga_tg_pkg::wrap_inc(32'(x_q), H_TOT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      x_q   <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
      x_q   <= x_d;
    end
  end
endmodule

// File: rtl/vga_vcount.sv
module vga_vcount #(
  parameter int SUB_W = 2,
  parameter int V_TOT = 131,
  localparam int YW = $clog2(V_TOT),
  localparam int PW = $clog2(V_TOT << SUB_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_step,
  output logic [SUB_W-1:0] sub_d,
  output logic [YW-1:0]    y_q,
  output logic [YW-1:0]    y_d,
  output logic [PW-1:0]    py_q,
  output logic             row_step,
  output logic             frame_wrap
);
  logic [SUB_W-1:0] sub_q;
  logic [PW-1:0]    py_d;

  assign row_step   = line_step && (&sub_q);
  assign frame_wrap = row_step && (y_q == YW'(V_TOT - 1));

  always_comb begin
    sub_d = line_step ? sub_q + SUB_W'(1) : sub_q;
    y_d   = row_step ? YW'(vga_tg_pkg::wrap_inc(32'(y_q), V_TOT)) : y_q;
    if (frame_wrap)     py_d = '0;
    else if (line_step) py_d = py_q + PW'(1);
    else                py_d = py_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      y_q   <= '0;
      py_q  <= '0;
    end else begin
      sub_q <= sub_d;
      y_q   <= y_d;
      py_q  <= py_d;
    end
  end
endmodule

// File: rtl/vga_sync_dec.sv
module vga_sync_dec #(
  parameter int XW = 8,
  parameter int YW = 8,
  parameter int SUB_W = 2,
  parameter int H_VIS = 160,
  parameter int H_SS = 164,
  parameter int H_SE = 188,
  parameter int V_VIS = 120,
  parameter int V_SS = 122,
  parameter int VS_SUB_END = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XW-1:0]    x_d,
  input  logic [YW-1:0]    y_d,
  input  logic [SUB_W-1:0] sub_d,
  output logic             hvis,
  output logic             vvis,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             de
);
  logic hvis_d, vvis_d, hs_act_d, vs_act_d;

  always_comb begin
    hvis_d   = 32'(x_d) < H_VIS;
    vvis_d   = 32'(y_d) < V_VIS;
    hs_act_d = vga_tg_pkg::in_span(32'(x_d), H_SS, H_SE);
    vs_act_d = (32'(y_d) == V_SS) && (32'(sub_d) < VS_SUB_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hvis    <= 1'b1;
      vvis    <= 1'b1;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      de      <= 1'b1;
    end else begin
      hvis    <= hvis_d;
      vvis    <= vvis_d;
      hsync_n <= !hs_act_d;
      vsync_n <= !vs_act_d;
      de      <= hvis_d && vvis_d;
    end
  end
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen #(
  parameter int DIV_W = 2,
  parameter int SUB_W = 2,
  parameter int H_TOT = 200,
  parameter int H_VIS = 160,
  parameter int H_SS = 164,
  parameter int H_SE = 188,
  parameter int V_TOT = 131,
  parameter int V_VIS = 120,
  parameter int V_SS = 122,
  parameter int VS_SUB_END = 2,
  localparam int XW = $clog2(H_TOT),
  localparam int YW = $clog2(V_TOT),
  localparam int PW = $clog2(V_TOT << SUB_W)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] vx_o,
  output logic [YW-1:0] vy_o,
  output logic [PW-1:0] line_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          hvis_o,
  output logic          vvis_o,
  output logic          de_o
);
  // Named internal events
  logic             x_tick, line_step, row_step, frame_wrap;
  logic [XW-1:0]    x_d;
  logic [YW-1:0]    y_d;
  logic [SUB_W-1:0] sub_d;

  vga_hcount #(.DIV_W(DIV_W), .H_TOT(H_TOT), .H_VIS(H_VIS)) u_h (
    .clk(clk), .rst(rst), .x_q(vx_o), .x_d(x_d),
    .x_tick(x_tick), .line_step(line_step)
  );

  vga_vcount #(.SUB_W(SUB_W), .V_TOT(V_TOT)) u_v (
    .clk(clk), .rst(rst), .line_step(line_step), .sub_d(sub_d),
    .y_q(vy_o), .y_d(y_d), .py_q(line_o),
    .row_step(row_step), .frame_wrap(frame_wrap)
  );

  vga_sync_dec #(
    .XW(XW), .YW(YW), .SUB_W(SUB_W), .H_VIS(H_VIS), .H_SS(H_SS), .H_SE(H_SE),
    .V_VIS(V_VIS), .V_SS(V_SS), .VS_SUB_END(VS_SUB_END)
  ) u_dec (
    .clk(clk), .rst(rst), .x_d(x_d), .y_d(y_d), .sub_d(sub_d),
    .hvis(hvis_o), .vvis(vvis_o), .hsync_n(hsync_n_o), .vsync_n(vsync_n_o), .de(de_o)
  );
endmodule

// File: rtl/vga_timing_chk.sv
module vga_timing_chk #(
  parameter int H_TOT = 200,
  parameter int H_VIS = 160,
  parameter int H_SS = 164,
  parameter int H_SE = 188,
  parameter int V_TOT = 131,
  parameter int V_SS = 122,
  parameter int XW = 8,
  parameter int YW = 8,
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [XW-1:0] x,
  input logic [YW-1:0] y,
  input logic [PW-1:0] line,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          hvis,
  input logic          vvis,
  input logic          de
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (x == '0 && y == '0 && line == '0 && hsync_n && vsync_n && hvis && vvis && de));

  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && x != $past(x)) |->
      (32'(x) == 32'($past(x)) + 1 || (x == '0 && 32'($past(x)) == H_TOT - 1)));

  // R3
  hvis_chk: assert property (@(posedge clk) disable iff (rst)
    hvis == (32'(x) < H_VIS));

  // R4
  hsync_chk: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> (32'(x) >= H_SS && 32'(x) < H_SE));

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && y != $past(y)) |-> (32'(x) == H_VIS));

  // R7
  vsync_row_chk: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> (32'(y) == V_SS));

  // R8
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && y == '0 && 32'($past(y)) == V_TOT - 1) |-> (line == '0));

  // R9
  de_chk: assert property (@(posedge clk) disable iff (rst)
    de == (hvis && vvis));
endmodule

bind vga_timing_gen vga_timing_chk #(
  .H_TOT(H_TOT), .H_VIS(H_VIS), .H_SS(H_SS), .H_SE(H_SE),
  .V_TOT(V_TOT), .V_SS(V_SS), .XW(XW), .YW(YW), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .x(vx_o), .y(vy_o), .line(line_o),
  .hsync_n(hsync_n_o), .vsync_n(vsync_n_o), .hvis(hvis_o), .vvis(vvis_o), .de(de_o)
);

// File: tb/sim_vga_timing_gen.sv
module sim_vga_timing_gen;
  localparam int VT = 9, VV = 6, VS = 7;
  localparam int YW = $clog2(VT);
  localparam int PW = $clog2(VT * 4);
  localparam int FRAME = VT * 4 * 800;

  logic clk = 0, rst = 1;
  logic [7:0] vx;
  logic [YW-1:0] vy;
  logic [PW-1:0] line;
  logic hs_n, vs_n, hv, vv, de;

  int vectors = 0, miscompares = 0, n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vga_timing_gen #(.V_TOT(VT), .V_VIS(VV), .V_SS(VS)) u0 (
    .clk(clk), .rst(rst), .vx_o(vx), .vy_o(vy), .line_o(line),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .hvis_o(hv), .vvis_o(vv), .de_o(de)
  );

  // Cycle counts (edges since reset) walked by the table loop
  localparam int NV = 24;
  localparam int TABLE [NV] = '{0, 1, 3, 4, 5, 639, 640, 643, 644, 655, 656, 751, 752,
                                799, 800, 801, 3039, 3040, 22239, 22240, 23839, 23840,
                                28639, 28640};

  task automatic chk(string tag, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  task automatic check_all();
    int xt, x, ls, sub, y, py, ehv, evv;
    vectors++;
    xt  = n / 4;
    x   = xt % 200;
    ls  = (xt + 40) / 200;
    sub = ls % 4;
    y   = (ls / 4) % VT;
    py  = ls % (4 * VT);
    ehv = (x < 160) ? 1 : 0;
    evv = (y < VV) ? 1 : 0;
    chk("R2 vx", int'(vx), x);
    chk("R5/R6 vy", int'(vy), y);
    chk("R8 line", int'(line), py);
    chk("R3 hvis", int'(hv), ehv);
    chk("R4 hsync_n", int'(hs_n), (x >= 164 && x < 188) ? 0 : 1);
    chk("R6 vvis", int'(vv), evv);
    chk("R7 vsync_n", int'(vs_n), (y == VS && sub < 2) ? 0 : 1);
    chk("R9 de", int'(de), ehv & evv);
  endtask

  task automatic tick();
    @(negedge clk);
    n++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    n = 0;
    // R1: reset state, R10: nothing moves before the first edge
    check_all();
    for (int i = 0; i < NV; i++) begin
      while (n < TABLE[i]) tick();
      check_all();
    end
    // Full sweep over two frames: every output on every cycle (R10)
    while (n < 2 * FRAME + 1000) begin
      tick();
      check_all();
    end
    // R1: reset in mid-frame
    rst = 1;
    @(negedge clk);
    rst = 0;
    n = 0;
    check_all();
    for (int k = 0; k < 900; k++) begin
      tick();
      check_all();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired at n=%0d", n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule